// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller in front of a multi-channel successive-approximation converter. Software programs it through a small register port. The settings are a module enable, a run bit, a scan mode (single pass or repeating), a trigger source (software, external pin or timer underflow), a supply-range code and a channel window. The block then steps the analog core through the channels of the window. For each channel it drives a channel number and a one-cycle start strobe, and it waits for the core's done handshake.

Each completed conversion lands in one result register and raises a completion flag that also drives the interrupt line. If a result is overwritten before software has read it, an overrun flag is set. A busy flag, separate from the run bit, shows whether the core is converting. A status field shows the channel being converted and, once the block is idle, the last converted channel, where channel 7 is shown as 0.

Changes of the run bit are sampled on a slow tick from the trigger timer. A set needs one tick to be seen and a clear needs two consecutive ticks, so short glitches are filtered out. Clearing the run bit never cuts a conversion short.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With module enable on, range code 3 and the software trigger (code 0), a recognised 0-to-1 change of the run bit starts a pass. The pass converts the channels first_ch, first_ch+1, ... last_ch in ascending order, with one start strobe per channel. The channel output does not change while a conversion is outstanding.
- R2: The run bit is not cleared by hardware when a pass ends and reads back as 1. A new pass needs the bit to be cleared and then set again. Holding it at 1 starts nothing further.
- R3: Clearing the run bit stops the sequence, but the conversion in flight runs until its done handshake, and busy stays 1 until then. After the stop no further start strobes are issued.
- R4: Busy reads 1 from the start strobe until the done handshake. It is 0 after reset, and it returns to 0 the cycle after module enable is cleared.
- R5: During a conversion the status field (STAT[6:4]) shows the channel being converted. When idle it shows the last converted channel, with channel 7 shown as 0.
- R6: With a range code other than 3, a recognised start performs no conversion.
- R7: In single-pass mode (CTRL[2]=0) the sequence stops after last_ch. In repeat mode (CTRL[2]=1) it repeats until the run bit is cleared.
- R8: The run bit is seen as set only after it reads 1 at one timer tick. It is seen as cleared only after it reads 0 at two consecutive ticks. A 1 that no tick sees starts nothing, and a 0 seen at only one tick does not restart a pass.
- R9: With trigger code 1 (external pin, rising edge) or 2 (timer underflow pulse), a recognised start only arms the block. Each trigger then runs one full pass. In repeat mode the block re-arms after the pass; in single-pass mode it goes idle. Code 3 never triggers.
- R10: Triggers that arrive while busy, or while the run bit is cleared, start nothing.
- R11: Each done handshake during a conversion latches the result into RESULT (address 2). It also sets the done flag (STAT[1]), which drives irq_o. Writing 1 to STAT[1] clears the flag.
- R12: A done handshake that arrives while the previous result is still unread sets the overrun flag (STAT[2]). Reading RESULT marks the result as read, and writing 1 to STAT[2] clears the flag.

Register map: address 0 is CTRL and reads back as written. Its fields are enable [0], run [1], mode [2], trigger [4:3], range [6:5], first_ch [10:8] and last_ch [14:12]. Address 1 is STAT, with busy in bit 0. Address 2 is RESULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on addr_i |
| tick_i | input | 1 | Trigger-timer clock tick, one cycle wide |
| ext_trig_i | input | 1 | External trigger pin, asynchronous |
| tmr_uf_i | input | 1 | Timer underflow pulse |
| conv_ch_o | output | 3 | Channel selected for the analog core |
| conv_start_o | output | 1 | One-cycle start strobe to the analog core |
| conv_done_i | input | 1 | Done handshake from the analog core |
| conv_data_i | input | 12 | Conversion result from the analog core |
| busy_o | output | 1 | Conversion in progress |
| irq_o | output | 1 | Completion interrupt |

## Verification
A sequencer whose channel counter is wrong shows up at the very next start strobe. The channel on conv_ch_o breaks the ascending order, and the number of strobes per pass no longer equals the window size. A state machine stuck in the converting state leaves busy_o high after the last done handshake. One that leaves too early drops busy_o and issues a strobe before the core has answered. Both are visible within one conversion latency. Filter or trigger-qualification faults appear as a pass that starts without a valid trigger or fails to start after one; the bench counts strobes over fixed windows of a few dozen cycles to catch these.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W  = 3;
  localparam int BUS_W = 16;
  localparam logic [CH_W-1:0] CH_TOP = '1;
  localparam logic [1:0] VR_RUN  = 2'd3;
  localparam logic [1:0] TRG_SW  = 2'd0;
  localparam logic [1:0] TRG_EXT = 2'd1;
  localparam logic [1:0] TRG_TMR = 2'd2;

  typedef struct packed {
    logic            mod_en;
    logic            run;
    logic            cont;
    logic [1:0]      trig;
    logic [1:0]      vrange;
    logic [CH_W-1:0] first_ch;
    logic [CH_W-1:0] last_ch;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_CONV} seq_state_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             done_evt_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             busy_i,
  input  logic [CH_W-1:0]  stat_ch_i,
  output ctrl_t            ctrl_o,
  output logic             irq_o
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RES  = 2'd2;

  logic [BUS_W-1:0] ctrl_raw;
  logic [RES_W-1:0] result_q;
  logic done_q, ovr_q, unread_q;
  logic stat_wr, res_rd;

  assign stat_wr = wr_en_i && addr_i == A_STAT;
  assign res_rd  = rd_en_i && addr_i == A_RES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_raw <= '0;
    else if (wr_en_i && addr_i == A_CTRL) ctrl_raw <= wdata_i;
  end

  assign ctrl_o.mod_en   = ctrl_raw[0];
  assign ctrl_o.run      = ctrl_raw[1];
  assign ctrl_o.cont     = ctrl_raw[2];
  assign ctrl_o.trig     = ctrl_raw[4:3];
  assign ctrl_o.vrange   = ctrl_raw[6:5];
  assign ctrl_o.first_ch = ctrl_raw[8 +: CH_W];
  assign ctrl_o.last_ch  = ctrl_raw[12 +: CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      unread_q <= 1'b0;
    end else if (done_evt_i) begin
      result_q <= res_i;
      done_q   <= 1'b1;
      unread_q <= 1'b1;
      if (unread_q) ovr_q <= 1'b1;
    end else begin
      if (stat_wr && wdata_i[1]) done_q <= 1'b0;
      if (stat_wr && wdata_i[2]) ovr_q  <= 1'b0;
      if (res_rd) unread_q <= 1'b0;
    end
  end

  assign irq_o = done_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o = ctrl_raw;
      A_STAT: begin
        rdata_o[0]          = busy_i;
        rdata_o[1]          = done_q;
        rdata_o[2]          = ovr_q;
        rdata_o[4 +: CH_W]  = stat_ch_i;
      end
      A_RES:   rdata_o[RES_W-1:0] = result_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_run_filt.sv
module adc_seq_run_filt #(
  parameter int SET_TICKS = 1,
  parameter int CLR_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic run_i,
  output logic run_o
);
  localparam int MAXT  = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);

  logic [CNT_W-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      run_o  <= 1'b0;
    end else if (!en_i) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      run_o  <= 1'b0;
    end else if (tick_i) begin
      if (run_i) begin
        lo_cnt <= '0;
        if (hi_cnt == CNT_W'(SET_TICKS - 1)) run_o <= 1'b1;
        else hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt == CNT_W'(CLR_TICKS - 1)) run_o <= 1'b0;
        else lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] src_i,
  input  logic       ext_i,
  input  logic       tmr_uf_i,
  output logic       trig_o
);
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_STAGES-1:0], ext_i};
  end

  logic ext_rise;
  assign ext_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  always_comb begin
    case (src_i)
      TRG_EXT: trig_o = ext_rise;
      TRG_TMR: trig_o = tmr_uf_i;
      default: trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctrl_t           ctrl_i,
  input  logic            run_f_i,
  input  logic            trig_i,
  input  logic            done_i,
  output logic [CH_W-1:0] ch_o,
  output logic            start_o,
  output logic            busy_o,
  output logic            done_evt_o,
  output logic [CH_W-1:0] stat_ch_o
);
  seq_state_e      state_q;
  logic [CH_W-1:0] cur_q;
  logic            run_d;
  logic            run_rise, last_pass;

  function automatic logic [CH_W-1:0] shown(input logic [CH_W-1:0] c);
    return (c == CH_TOP) ? '0 : c;
  endfunction

  assign run_rise   = run_f_i && !run_d;
  assign last_pass  = cur_q >= ctrl_i.last_ch;
  assign busy_o     = state_q == ST_CONV;
  assign done_evt_o = busy_o && done_i;
  assign ch_o       = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      stat_ch_o <= '0;
      run_d     <= 1'b0;
      start_o   <= 1'b0;
    end else begin
      run_d   <= run_f_i;
      start_o <= 1'b0;
      if (!ctrl_i.mod_en) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (run_rise && ctrl_i.vrange == VR_RUN) begin
              cur_q     <= ctrl_i.first_ch;
              stat_ch_o <= ctrl_i.first_ch;
              if (ctrl_i.trig == TRG_SW) begin
                state_q <= ST_CONV;
                start_o <= 1'b1;
              end else begin
                state_q <= ST_ARMED;
              end
            end
          end
          ST_ARMED: begin
            if (!run_f_i) begin
              state_q <= ST_IDLE;
            end else if (trig_i) begin
              state_q   <= ST_CONV;
              start_o   <= 1'b1;
              stat_ch_o <= cur_q;
            end
          end
          ST_CONV: begin
            if (done_i) begin
              if (!run_f_i || (last_pass && !ctrl_i.cont)) begin
                state_q   <= ST_IDLE;
                stat_ch_o <= shown(cur_q);
              end else if (last_pass) begin
                cur_q <= ctrl_i.first_ch;
                if (ctrl_i.trig == TRG_SW) begin
                  start_o   <= 1'b1;
                  stat_ch_o <= ctrl_i.first_ch;
                end else begin
                  state_q   <= ST_ARMED;
                  stat_ch_o <= shown(cur_q);
                end
              end else begin
                cur_q     <= cur_q + 1'b1;
                stat_ch_o <= cur_q + 1'b1;
                start_o   <= 1'b1;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int SET_TICKS = 1,
  parameter int CLR_TICKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             tick_i,
  input  logic             ext_trig_i,
  input  logic             tmr_uf_i,
  output logic [CH_W-1:0]  conv_ch_o,
  output logic             conv_start_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             busy_o,
  output logic             irq_o
);
  ctrl_t           ctrl;
  logic            mod_en, run_f, trig, done_evt;
  logic [CH_W-1:0] stat_ch;

  assign mod_en = ctrl.mod_en;

  adc_seq_regs #(.RES_W(RES_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .done_evt_i(done_evt), .res_i(conv_data_i), .busy_i(busy_o),
    .stat_ch_i(stat_ch), .ctrl_o(ctrl), .irq_o(irq_o)
  );

  adc_seq_run_filt #(.SET_TICKS(SET_TICKS), .CLR_TICKS(CLR_TICKS)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mod_en), .tick_i(tick_i),
    .run_i(ctrl.run), .run_o(run_f)
  );

  adc_seq_trig u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(ctrl.trig), .ext_i(ext_trig_i),
    .tmr_uf_i(tmr_uf_i), .trig_o(trig)
  );

  adc_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl), .run_f_i(run_f),
    .trig_i(trig), .done_i(conv_done_i), .ch_o(conv_ch_o),
    .start_o(conv_start_o), .busy_o(busy_o), .done_evt_o(done_evt),
    .stat_ch_o(stat_ch)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mod_en_i,
  input logic            conv_start_i,
  input logic            conv_done_i,
  input logic            busy_i,
  input logic            irq_i,
  input logic [CH_W-1:0] ch_i
);
  assert_start_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |-> busy_i);

  assert_ch_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !conv_done_i && mod_en_i) |=> $stable(ch_i));

  assert_busy_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !conv_done_i && mod_en_i) |=> busy_i);

  assert_modoff_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> !busy_i);

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |-> (!$past(busy_i) || $past(conv_done_i)));

  assert_done_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && conv_done_i) |=> irq_i);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(adc_seq_pkg::CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mod_en_i(mod_en),
  .conv_start_i(conv_start_o), .conv_done_i(conv_done_i),
  .busy_i(busy_o), .irq_i(irq_o), .ch_i(conv_ch_o)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  localparam int LAT = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        tick_i = 1'b0, ext_trig_i = 1'b0, tmr_uf_i = 1'b0;
  logic [2:0]  conv_ch_o;
  logic        conv_start_o;
  logic        conv_done_i = 1'b0;
  logic [11:0] conv_data_i = '0;
  logic        busy_o, irq_o;

  always #5 clk_i = ~clk_i;

  adc_seq_ctrl u_adc_seq_ctrl (.*);

  int n_run = 0, n_fail = 0;
  int n_conv = 0, n_done = 0, seq = 0;
  logic [2:0] log_ch [512];
  bit tick_en = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input bit en, input bit run, input bit cont,
      input logic [1:0] trg, input logic [1:0] vr, input logic [2:0] f, input logic [2:0] l);
    logic [15:0] w = '0;
    w[0] = en; w[1] = run; w[2] = cont; w[4:3] = trg; w[6:5] = vr;
    w[10:8] = f; w[14:12] = l;
    return w;
  endfunction

  function automatic int shown(input int c);
    return (c == 7) ? 0 : c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i); addr_i = a; rd_en_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(ref logic s, input int len);
    @(negedge clk_i); s = 1'b1;
    repeat (len) @(negedge clk_i);
    s = 1'b0;
  endtask

  // timer tick every 4 cycles
  initial forever begin
    repeat (3) @(negedge clk_i);
    tick_i = tick_en;
    @(negedge clk_i);
    tick_i = 1'b0;
  end

  // fixed-latency analog core model
  initial begin
    logic [2:0] ch_cap;
    forever begin
      @(negedge clk_i);
      conv_done_i = 1'b0;
      if (conv_start_o) begin
        ch_cap = conv_ch_o;
        if (n_conv < 512) log_ch[n_conv] = ch_cap;
        n_conv++;
        repeat (LAT - 1) @(negedge clk_i);
        seq++;
        conv_data_i = {ch_cap, 9'(seq)};
        conv_done_i = 1'b1;
        n_done++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int base, f, l;
    void'($urandom(32'd1234));
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);

    // reset state (R4)
    rd(2'd0, d); chk(d == 0, "R4 reset ctrl", d, 0);
    rd(2'd1, d); chk(d == 0, "R4 reset stat", d, 0);
    rd(2'd2, d); chk(d == 0, "R11 reset result", d, 0);
    chk(!busy_o && !conv_start_o, "R4 reset busy", busy_o, 0);

    // random single-pass software scans (R1, R5, R7, R11, R2)
    for (int i = 0; i < 20; i++) begin
      f = $urandom_range(0, 7);
      l = (i == 0) ? 7 : $urandom_range(f, 7);
      wr(2'd0, mk_ctrl(1, 0, 0, 2'd0, 2'd3, f[2:0], l[2:0]));
      wait_cyc(20);
      n_conv = 0;
      wr(2'd0, mk_ctrl(1, 1, 0, 2'd0, 2'd3, f[2:0], l[2:0]));
      wait_cyc(30 + 8 * (l - f + 1));
      chk(n_conv == l - f + 1, "R7 single-pass count", n_conv, l - f + 1);
      for (int k = 0; k < n_conv && k < 8; k++)
        chk(log_ch[k] == 3'(f + k), "R1 channel order", log_ch[k], f + k);
      chk(!busy_o, "R4 idle after pass", busy_o, 0);
      rd(2'd1, d); chk(d[6:4] == 3'(shown(l)), "R5 status after pass", d[6:4], shown(l));
      rd(2'd2, d); chk(d[11:9] == 3'(l), "R11 result channel", d[11:9], l);
      rd(2'd0, d); chk(d[1] == 1'b1, "R2 run bit stays set", d[1], 1);
    end

    // no new pass while run bit held (R2)
    base = n_conv;
    wait_cyc(100);
    chk(n_conv == base, "R2 no restart without toggle", n_conv, base);

    // status wrap: pass ending on channel 7 (R5)
    wr(2'd0, mk_ctrl(1, 0, 0, 2'd0, 2'd3, 3'd6, 3'd7)); wait_cyc(20);
    wr(2'd0, mk_ctrl(1, 1, 0, 2'd0, 2'd3, 3'd6, 3'd7)); wait_cyc(60);
    rd(2'd1, d); chk(d[6:4] == 0, "R5 channel 7 shown as 0", d[6:4], 0);

    // short zero glitch, one tick at most (R8)
    base = n_conv;
    wr(2'd0, mk_ctrl(1, 0, 0, 2'd0, 2'd3, 3'd6, 3'd7));
    wr(2'd0, mk_ctrl(1, 1, 0, 2'd0, 2'd3, 3'd6, 3'd7));
    wait_cyc(80);
    chk(n_conv == base, "R8 one-tick clear ignored", n_conv, base);

    // set with no tick seen (R8)
    wr(2'd0, mk_ctrl(1, 0, 0, 2'd0, 2'd3, 3'd0, 3'd1)); wait_cyc(20);
    @(negedge clk_i); tick_en = 1'b0; wait_cyc(6);
    base = n_conv;
    wr(2'd0, mk_ctrl(1, 1, 0, 2'd0, 2'd3, 3'd0, 3'd1));
    wr(2'd0, mk_ctrl(1, 0, 0, 2'd0, 2'd3, 3'd0, 3'd1));
    wait_cyc(2); tick_en = 1'b1;
    wait_cyc(60);
    chk(n_conv == base, "R8 unsampled set ignored", n_conv, base);

    // range code other than 3 (R6)
    wr(2'd0, mk_ctrl(1, 1, 0, 2'd0, 2'd1, 3'd0, 3'd3));
    wait_cyc(60);
    chk(n_conv == base && !busy_o, "R6 no conversion", n_conv, base);

    // external trigger, single pass (R9)
    wr(2'd0, mk_ctrl(1, 0, 0, 2'd1, 2'd3, 3'd2, 3'd4)); wait_cyc(20);
    n_conv = 0;
    wr(2'd0, mk_ctrl(1, 1, 0, 2'd1, 2'd3, 3'd2, 3'd4));
    wait_cyc(50);
    chk(n_conv == 0, "R9 armed waits for trigger", n_conv, 0);
    pulse(ext_trig_i, 3);
    wait_cyc(60);
    chk(n_conv == 3, "R9 ext trigger pass", n_conv, 3);
    chk(log_ch[0] == 3'd2, "R9 pass first channel", log_ch[0], 2);

    // trigger while run bit cleared (R10)
    wr(2'd0, mk_ctrl(1, 0, 0, 2'd1, 2'd3, 3'd2, 3'd4)); wait_cyc(20);
    pulse(ext_trig_i, 3); wait_cyc(50);
    chk(n_conv == 3, "R10 trigger with run cleared", n_conv, 3);

    // timer trigger, repeat mode, trigger during busy (R10, R7, R9)
    n_conv = 0;
    wr(2'd0, mk_ctrl(1, 1, 1, 2'd2, 2'd3, 3'd0, 3'd3)); wait_cyc(20);
    pulse(tmr_uf_i, 1);
    wait_cyc(3);
    chk(busy_o == 1'b1, "R4 busy during conversion", busy_o, 1);
    pulse(tmr_uf_i, 1);
    wait_cyc(60);
    chk(n_conv == 4, "R10 trigger while busy ignored", n_conv, 4);
    pulse(tmr_uf_i, 1);
    wait_cyc(60);
    chk(n_conv == 8, "R9 repeat mode re-arms", n_conv, 8);

    // stop in repeat mode lets in-flight conversion finish (R3, R7)
    wr(2'd0, mk_ctrl(1, 0, 0, 2'd0, 2'd3, 3'd0, 3'd7)); wait_cyc(20);
    n_conv = 0; n_done = 0;
    wr(2'd0, mk_ctrl(1, 1, 1, 2'd0, 2'd3, 3'd0, 3'd7));
    wait_cyc(120);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'd0, 2'd3, 3'd0, 3'd7));
    wait_cyc(40);
    chk(n_conv > 8, "R7 repeat continues past window", n_conv, 9);
    chk(n_done == n_conv, "R3 in-flight completed", n_done, n_conv);
    chk(!busy_o, "R3 idle after stop", busy_o, 0);
    rd(2'd1, d);
    chk(d[6:4] == 3'(shown(log_ch[n_conv - 1])), "R5 status after stop",
        d[6:4], shown(log_ch[n_conv - 1]));
    base = n_conv; wait_cyc(60);
    chk(n_conv == base, "R3 no start after stop", n_conv, base);

    // flags (R11, R12)
    rd(2'd1, d);
    chk(d[2] == 1'b1, "R12 overrun set", d[2], 1);
    chk(d[1] == 1'b1 && irq_o, "R11 done flag and irq", d[1], 1);
    wr(2'd1, 16'h0006);
    rd(2'd1, d);
    chk(d[2:1] == 0 && !irq_o, "R11 R12 flags cleared", d[2:1], 0);
    rd(2'd2, d);
    wr(2'd0, mk_ctrl(1, 1, 0, 2'd0, 2'd3, 3'd5, 3'd5)); wait_cyc(40);
    rd(2'd1, d);
    chk(d[2] == 1'b0 && d[1] == 1'b1, "R12 no overrun after read", d[2], 0);

    // module enable cleared mid-run (R4)
    wr(2'd0, mk_ctrl(1, 0, 1, 2'd0, 2'd3, 3'd0, 3'd7)); wait_cyc(20);
    wr(2'd0, mk_ctrl(1, 1, 1, 2'd0, 2'd3, 3'd0, 3'd7)); wait_cyc(30);
    wr(2'd0, mk_ctrl(0, 1, 1, 2'd0, 2'd3, 3'd0, 3'd7));
    wait_cyc(1);
    chk(!busy_o, "R4 busy cleared by enable off", busy_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule